// File: doc/BRIEF.md
# Integer Instruction Execute Unit

This block executes one 32-bit integer instruction per clock. It takes the instruction word together with the two source operand values that a register file has already read. It cuts the word into its fields and works out which operation is meant. It prepares the immediate and computes the result. One cycle later it presents the result, the destination register index and a write strobe. It also sends the two source register indices back out, so the register file can be addressed from the same word.

Two encodings are handled. With opcode zero, the register-register operations are selected by the function code: add, subtract, AND, OR, NOR, signed and unsigned set-on-less-than, and logical shifts by a constant amount. A non-zero opcode selects an immediate operation: add, signed and unsigned set-less-than, AND, OR, or load-upper. Each immediate opcode chooses for itself whether its 16-bit constant is sign-extended or zero-extended. The unsigned compare lets software test `0 <= x < limit` in one step, because a negative `x` looks like a very large unsigned number.

Any encoding outside this set raises an illegal flag and suppresses the write. A write aimed at register 0 is also suppressed.

The execute stage is a single registered step with two named states per issue slot. The IDLE state means no instruction was captured on the last edge, so `out_valid` is low. The BUSY state means the outputs hold the result of the instruction captured on the last edge. There are four transitions:
- ISSUE takes IDLE to BUSY when `in_valid` is high.
- DRAIN takes BUSY to IDLE when `in_valid` is low.
- STREAM keeps BUSY when `in_valid` stays high.
- REST keeps IDLE when `in_valid` stays low.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, funct 0x20 gives `a + b` and funct 0x22 gives `a - b`, both modulo 2^32. Here `a` is the operand for the field in bits [25:21] (rs) and `b` is the operand for the field in bits [20:16] (rt).
- R2: With opcode 0, funct 0x24 gives `a & b`, funct 0x25 gives `a | b`, and funct 0x27 gives `~(a | b)`.
- R3: With opcode 0 and funct 0x2A, the result is 1 when `a < b` as signed two's-complement values and 0 otherwise.
- R4: With opcode 0 and funct 0x2B, the result is 1 when `a < b` as unsigned values and 0 otherwise. A negative `a` therefore fails against any positive limit.
- R5: With opcode 0, funct 0x00 shifts `b` left and funct 0x02 shifts `b` right. The distance comes from bits [10:6], from 0 to 31, and vacated bits are filled with zeros.
- R6: Opcodes 0x08 (add), 0x0A (signed less-than) and 0x0B (unsigned less-than) use `a` against the immediate in bits [15:0], sign-extended to 32 bits.
- R7: Opcodes 0x0C (AND) and 0x0D (OR) use `a` against the immediate, zero-extended to 32 bits.
- R8: Opcode 0x0F gives the immediate in bits [31:16] of the result, with bits [15:0] cleared.
- R9: Register-register results target the index in bits [15:11]; immediate results target the index in bits [20:16]. `src_a_idx` always shows bits [25:21] and `src_b_idx` always shows bits [20:16].
- R10: A legal instruction whose destination index is 0 produces `out_wr` low. A legal instruction with a non-zero destination produces `out_wr` high.
- R11: Any other opcode, or opcode 0 with any other funct, produces `out_illegal` high, `out_wr` low and a result of 0.
- R12: Outputs appear on the clock edge after the edge that sampled `in_valid` high. `out_valid` is low after any edge that sampled `in_valid` low, and during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| in_instr | input | 32 | Instruction word |
| in_opa | input | 32 | Value of the register named in bits [25:21] |
| in_opb | input | 32 | Value of the register named in bits [20:16] |
| src_a_idx | output | 5 | First source register index, combinational |
| src_b_idx | output | 5 | Second source register index, combinational |
| out_valid | output | 1 | Result registers hold a captured instruction |
| out_result | output | 32 | Computed result |
| out_dest | output | 5 | Destination register index |
| out_wr | output | 1 | Register write enable |
| out_illegal | output | 1 | Captured encoding is not in the supported set |

## Verification
The assertions assume that `in_instr` is a known value whenever `in_valid` is high, and that nothing about the instruction is implied on cycles where `in_valid` is low. Their checks of the result register therefore key only on edges where `in_valid` was sampled high. The stimulus changes inputs only on the falling clock edge. It keeps the instruction fields fully defined on every issued word. It also drops `in_valid` between bursts, so that the draining path is exercised as well as back-to-back issue.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int ILEN   = 32;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int SH_W   = 5;
    localparam int FN_W   = 6;
    localparam int IMM_W  = 16;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLT,
        ALU_SLTU,
        ALU_SLL,
        ALU_SRL,
        ALU_LUI,
        ALU_NONE
    } alu_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } exu_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [SH_W-1:0]  shamt;
        logic [FN_W-1:0]  funct;
    } instr_fields_t;

    typedef struct packed {
        alu_op_e          op;
        logic             use_imm;
        logic             sign_ext;
        logic             illegal;
        logic [REG_W-1:0] dest;
        logic [SH_W-1:0]  shamt;
        logic [IMM_W-1:0] imm;
    } decoded_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [ILEN-1:0]  instr,
    output logic [REG_W-1:0] rs_idx,
    output logic [REG_W-1:0] rt_idx,
    output decoded_t         dec
);

    instr_fields_t f;

    assign f      = instr_fields_t'(instr);
    assign rs_idx = f.rs;
    assign rt_idx = f.rt;

    alu_op_e          op_r;
    logic             ill_r;
    alu_op_e          op_i;
    logic             ill_i;
    logic             sext_i;

    // register-register selection by function code
    always_comb begin
        op_r  = ALU_NONE;
        ill_r = 1'b0;
        unique case (f.funct)
            FN_ADD:  op_r = ALU_ADD;
            FN_SUB:  op_r = ALU_SUB;
            FN_AND:  op_r = ALU_AND;
            FN_OR:   op_r = ALU_OR;
            FN_NOR:  op_r = ALU_NOR;
            FN_SLT:  op_r = ALU_SLT;
            FN_SLTU: op_r = ALU_SLTU;
            FN_SLL:  op_r = ALU_SLL;
            FN_SRL:  op_r = ALU_SRL;
            default: ill_r = 1'b1;
        endcase
    end

    // immediate selection by opcode, with the extension rule per opcode
    always_comb begin
        op_i   = ALU_NONE;
        ill_i  = 1'b0;
        sext_i = 1'b0;
        unique case (f.opcode)
            OPC_ADDI: begin
                op_i   = ALU_ADD;
                sext_i = 1'b1;
            end
            OPC_SLTI: begin
                op_i   = ALU_SLT;
                sext_i = 1'b1;
            end
            OPC_SLTIU: begin
                op_i   = ALU_SLTU;
                sext_i = 1'b1;
            end
            OPC_ANDI: op_i = ALU_AND;
            OPC_ORI:  op_i = ALU_OR;
            OPC_LUI:  op_i = ALU_LUI;
            default:  ill_i = 1'b1;
        endcase
    end

    logic is_reg;
    assign is_reg = (f.opcode == OPC_REG);

    always_comb begin
        dec.shamt = f.shamt;
        dec.imm   = instr[IMM_W-1:0];
        if (is_reg) begin
            dec.op       = op_r;
            dec.use_imm  = 1'b0;
            dec.sign_ext = 1'b0;
            dec.illegal  = ill_r;
            dec.dest     = f.rd;
        end else begin
            dec.op       = op_i;
            dec.use_imm  = 1'b1;
            dec.sign_ext = sext_i;
            dec.illegal  = ill_i;
            dec.dest     = f.rt;
        end
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] din,
    input  logic [SH_W-1:0] amount,
    input  logic            to_left,
    output logic [XLEN-1:0] dout
);

    localparam int STAGES = SH_W;

    logic [XLEN-1:0] stage [STAGES+1];

    // one mux stage per shift-amount bit, zero fill either direction
    assign stage[0] = din;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int DIST = 1 << s;
        logic [XLEN-1:0] moved;
        always_comb begin
            if (to_left) moved = stage[s] << DIST;
            else         moved = stage[s] >> DIST;
        end
        assign stage[s+1] = amount[s] ? moved : stage[s];
    end

    assign dout = stage[STAGES];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SH_W-1:0] shamt,
    output logic [XLEN-1:0] y
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] diff;
    logic            lt_s;
    logic            lt_u;
    logic [XLEN-1:0] shifted;
    logic            shl;

    assign sum  = a + b;
    assign diff = a - b;
    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;
    assign shl  = (op == ALU_SLL);

    exu_shifter #(.XLEN(XLEN)) u_shift (
        .din     (b),
        .amount  (shamt),
        .to_left (shl),
        .dout    (shifted)
    );

    always_comb begin
        unique case (op)
            ALU_ADD:  y = sum;
            ALU_SUB:  y = diff;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            ALU_SLL,
            ALU_SRL:  y = shifted;
            ALU_LUI:  y = {b[HALF-1:0], {HALF{1'b0}}};
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ILEN-1:0]  in_instr,
    input  logic [XLEN-1:0]  in_opa,
    input  logic [XLEN-1:0]  in_opb,
    output logic [REG_W-1:0] src_a_idx,
    output logic [REG_W-1:0] src_b_idx,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_result,
    output logic [REG_W-1:0] out_dest,
    output logic             out_wr,
    output logic             out_illegal
);

    localparam int EXT_W = XLEN - IMM_W;

    decoded_t        dec;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] alu_y;

    exu_decode u_dec (
        .instr  (in_instr),
        .rs_idx (src_a_idx),
        .rt_idx (src_b_idx),
        .dec    (dec)
    );

    assign imm_ext = dec.sign_ext ? {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm}
                                  : {{EXT_W{1'b0}}, dec.imm};
    assign opnd_b  = dec.use_imm ? imm_ext : in_opb;

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op    (dec.op),
        .a     (in_opa),
        .b     (opnd_b),
        .shamt (dec.shamt),
        .y     (alu_y)
    );

    exu_state_e state_q;
    exu_state_e state_d;

    // transitions ISSUE / STREAM go to BUSY, DRAIN / REST go to IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_BUSY : ST_IDLE;
            ST_BUSY: state_d = in_valid ? ST_BUSY : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    logic            wr_d;
    logic [XLEN-1:0] res_d;

    assign wr_d  = in_valid && !dec.illegal && (dec.dest != '0);
    assign res_d = dec.illegal ? '0 : alu_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_dest    <= '0;
            out_wr      <= 1'b0;
            out_illegal <= 1'b0;
        end else if (in_valid) begin
            out_result  <= res_d;
            out_dest    <= dec.dest;
            out_wr      <= wr_d;
            out_illegal <= dec.illegal;
        end else begin
            out_wr      <= 1'b0;
            out_illegal <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_BUSY);

endmodule

// File: rtl/exu_chk.sv
module exu_chk
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ILEN-1:0]  in_instr,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_result,
    input logic [REG_W-1:0] out_dest,
    input logic             out_wr,
    input logic             out_illegal
);

    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr)); // R12

    AST_NO_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (out_dest != '0)); // R10

    AST_ILLEGAL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_wr && out_result == '0)); // R11

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[31:26] == OPC_SLTI) |=> (out_result[XLEN-1:1] == '0)); // R6

    AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[31:26] == OPC_LUI) |=> (out_result[15:0] == '0)); // R8

    AST_IMM_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[31:26] == OPC_ORI) |=> (out_dest == $past(in_instr[20:16]))); // R9

endmodule

bind int_exec_unit exu_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_dest    (out_dest),
    .out_wr      (out_wr),
    .out_illegal (out_illegal)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  dest;
        logic        wr;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_opa = '0;
    logic [31:0] in_opb = '0;
    logic [4:0]  src_a_idx, src_b_idx;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_dest;
    logic        out_wr;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .in_opa      (in_opa),
        .in_opb      (in_opb),
        .src_a_idx   (src_a_idx),
        .src_b_idx   (src_b_idx),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_dest    (out_dest),
        .out_wr      (out_wr),
        .out_illegal (out_illegal)
    );

    function automatic logic [31:0] rw(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [4:0] sh,
                                       input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] opc, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {opc, rs, rt, imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: present one instruction, queue its expected outcome
    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] res, input logic [4:0] dest, input logic wr,
                         input logic ill, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = ins;
        in_opa   = a;
        in_opb   = b;
        #1;
        check({tag, " src_a"}, {27'b0, src_a_idx}, {27'b0, ins[25:21]});
        check({tag, " src_b"}, {27'b0, src_b_idx}, {27'b0, ins[20:16]});
        e.res = res; e.dest = dest; e.wr = wr; e.ill = ill; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_instr = 32'hFFFF_FFFF;
        end
    endtask

    // monitor: compare each valid result against the oldest queued item
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R12 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " result"}, out_result, e.res);
                    check({e.tag, " dest"}, {27'b0, out_dest}, {27'b0, e.dest});
                    check({e.tag, " wr"}, {31'b0, out_wr}, {31'b0, e.wr});
                    check({e.tag, " illegal"}, {31'b0, out_illegal}, {31'b0, e.ill});
                end
            end else begin
                check("R12 quiet wr", {31'b0, out_wr}, 32'd0);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R12 reset valid", {31'b0, out_valid}, 32'd0);
        check("R12 reset wr", {31'b0, out_wr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 add/sub with wraparound, R9 rd destination
        issue(rw(5'd1, 5'd2, 5'd3, 5'd0, 6'h20), 32'd5, 32'd7, 32'd12, 5'd3, 1, 0, "R1 R9 add");
        issue(rw(5'd4, 5'd5, 5'd6, 5'd0, 6'h20), 32'hFFFF_FFFF, 32'd2, 32'd1, 5'd6, 1, 0, "R1 add wrap");
        issue(rw(5'd4, 5'd5, 5'd7, 5'd0, 6'h22), 32'd3, 32'd5, 32'hFFFF_FFFE, 5'd7, 1, 0, "R1 sub");
        // R2 logic
        issue(rw(5'd1, 5'd2, 5'd8, 5'd0, 6'h24), 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h00F0_F000, 5'd8, 1, 0, "R2 and");
        issue(rw(5'd1, 5'd2, 5'd9, 5'd0, 6'h25), 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'hFFF0_FFF0, 5'd9, 1, 0, "R2 or");
        issue(rw(5'd1, 5'd2, 5'd10, 5'd0, 6'h27), 32'hF0F0_FF00, 32'h0FF0_F0F0, 32'h000F_000F, 5'd10, 1, 0, "R2 nor");
        idle(2);
        // R3 signed compare
        issue(rw(5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'hFFFF_FFFF, 32'd1, 32'd1, 5'd11, 1, 0, "R3 slt neg<pos");
        issue(rw(5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'd1, 32'hFFFF_FFFF, 32'd0, 5'd11, 1, 0, "R3 slt pos<neg");
        issue(rw(5'd1, 5'd2, 5'd11, 5'd0, 6'h2A), 32'd4, 32'd4, 32'd0, 5'd11, 1, 0, "R3 slt equal");
        // R4 unsigned compare as bounds check
        issue(rw(5'd1, 5'd2, 5'd12, 5'd0, 6'h2B), 32'hFFFF_FFFF, 32'd10, 32'd0, 5'd12, 1, 0, "R4 sltu negative index");
        issue(rw(5'd1, 5'd2, 5'd12, 5'd0, 6'h2B), 32'd3, 32'd10, 32'd1, 5'd12, 1, 0, "R4 sltu in range");
        issue(rw(5'd1, 5'd2, 5'd12, 5'd0, 6'h2B), 32'd10, 32'd10, 32'd0, 5'd12, 1, 0, "R4 sltu at limit");
        // R5 shifts
        issue(rw(5'd0, 5'd2, 5'd13, 5'd31, 6'h00), 32'hDEAD_BEEF, 32'd1, 32'h8000_0000, 5'd13, 1, 0, "R5 sll 31");
        issue(rw(5'd0, 5'd2, 5'd13, 5'd31, 6'h02), 32'd0, 32'h8000_0001, 32'd1, 5'd13, 1, 0, "R5 srl 31");
        issue(rw(5'd0, 5'd2, 5'd13, 5'd0, 6'h00), 32'd0, 32'h1234_5678, 32'h1234_5678, 5'd13, 1, 0, "R5 sll 0");
        issue(rw(5'd0, 5'd2, 5'd13, 5'd4, 6'h02), 32'd0, 32'hFFFF_FFFF, 32'h0FFF_FFFF, 5'd13, 1, 0, "R5 srl zero fill");
        issue(rw(5'd0, 5'd2, 5'd13, 5'd8, 6'h00), 32'd0, 32'h00AB_CDEF, 32'hABCD_EF00, 5'd13, 1, 0, "R5 sll 8");
        idle(1);
        // R6 sign-extended immediates, R9 rt destination
        issue(iw(6'h08, 5'd1, 5'd14, 16'hFFFF), 32'd10, 32'hAAAA_AAAA, 32'd9, 5'd14, 1, 0, "R6 R9 addi");
        issue(iw(6'h0A, 5'd1, 5'd15, 16'hFFFC), 32'hFFFF_FFFB, 32'd0, 32'd1, 5'd15, 1, 0, "R6 slti");
        issue(iw(6'h0A, 5'd1, 5'd15, 16'h0005), 32'd5, 32'd0, 32'd0, 5'd15, 1, 0, "R6 slti equal");
        issue(iw(6'h0B, 5'd1, 5'd16, 16'hFFFF), 32'd5, 32'd0, 32'd1, 5'd16, 1, 0, "R6 sltiu");
        // R7 zero-extended immediates
        issue(iw(6'h0C, 5'd1, 5'd17, 16'h8001), 32'hFFFF_FFFF, 32'd0, 32'h0000_8001, 5'd17, 1, 0, "R7 andi");
        issue(iw(6'h0D, 5'd1, 5'd18, 16'hFFFF), 32'd0, 32'hFFFF_FFFF, 32'h0000_FFFF, 5'd18, 1, 0, "R7 ori");
        // R8 load upper
        issue(iw(6'h0F, 5'd9, 5'd19, 16'hABCD), 32'h1111_1111, 32'h2222_2222, 32'hABCD_0000, 5'd19, 1, 0, "R8 lui");
        // R10 register 0 destination
        issue(rw(5'd1, 5'd2, 5'd0, 5'd0, 6'h20), 32'd1, 32'd2, 32'd3, 5'd0, 0, 0, "R10 rd zero");
        issue(iw(6'h08, 5'd1, 5'd0, 16'h0001), 32'd1, 32'd0, 32'd2, 5'd0, 0, 0, "R10 rt zero");
        // R11 illegal encodings
        issue(iw(6'h23, 5'd1, 5'd20, 16'h0004), 32'd1, 32'd2, 32'd0, 5'd20, 0, 1, "R11 bad opcode");
        issue(rw(5'd1, 5'd2, 5'd21, 5'd0, 6'h21), 32'd1, 32'd2, 32'd0, 5'd21, 0, 1, "R11 bad funct");
        issue(iw(6'h02, 5'd0, 5'd0, 16'h0000), 32'd7, 32'd7, 32'd0, 5'd0, 0, 1, "R11 jump opcode");
        idle(3);

        // final drain: the queue must be empty
        check("R12 all results seen", sb.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule